// File: doc/BRIEF.md
# Segmented instruction prefetch unit

This block is the code-fetch half of a processor bus interface. It keeps a code segment and a fetch offset. From them it builds a 20-bit physical byte address: the segment is moved up four bit positions and the offset is added. It issues fetch requests on a 16-bit data bus and marks the wanted byte lanes. Every returned byte goes into a small byte queue. The execution side drains the queue one byte per request.

Fetching runs in the background whenever the queue has room for the next transfer and no operand access has claimed the bus. Only one fetch is outstanding at a time. A flush loads a new segment and offset, for example after a jump. It empties the queue at once, drops the data of a fetch that is still outstanding, and restarts fetching at the new location.

The queue depth and the bus width are parameters. An 8-bit bus with a 4-byte queue is a supported variant.

Top module: `pf_prefetch_unit`

## Requirements
- R1: `req_addr` equals (segment × 16 + offset) modulo 2^20, so a sum above FFFFFh wraps to the bottom of the address space (segment FFFFh with offset 0010h gives 00000h).
- R2: After reset the queue is empty and the first fetch request is for FFFF0h (segment F000h, offset FFF0h).
- R3: On the 16-bit bus, a request drives `req_bhe_n`=0. With `req_addr[0]`=1 only the high lane (bits 15:8) is taken, as one byte. With `req_addr[0]`=0 both lanes are taken, low lane first and then high lane. `req_bhe_n` is 1 while no request is offered.
- R4: An even-address request is offered only when at least two queue slots are free. An odd-address request needs one free slot. The free count is measured at the start of the cycle.
- R5: The queue holds `Q_DEPTH` bytes (6 by default). It never overflows. Bytes leave it in ascending offset order.
- R6: While `op_claim` is 1, no fetch request is offered.
- R7: At most one fetch is outstanding. A request is offered in every cycle with no outstanding fetch, no claim, no flush and enough room, and in no other cycle.
- R8: A flush empties the queue, so `pop_valid` is 0 in the next cycle. The response of a fetch outstanding at the flush, including one landing in the flush cycle, is discarded. The next request uses the new segment and offset.
- R9: The offset advances by the number of bytes actually written into the queue and wraps within 16 bits while the segment stays unchanged.
- R10: `pop_valid` is 1 whenever the queue holds a byte. `pop_byte` is the oldest byte. One byte is removed in each cycle with `pop_req`=1 and `pop_valid`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Reload segment and offset and empty the queue |
| flush_seg | input | 16 | New code segment on flush |
| flush_off | input | 16 | New fetch offset on flush |
| op_claim | input | 1 | Operand access owns the bus; blocks new fetches |
| req_valid | output | 1 | Fetch request offered |
| req_ready | input | 1 | Bus accepts the request |
| req_addr | output | 20 | Physical fetch address |
| req_bhe_n | output | 1 | High-lane enable, active low |
| rsp_valid | input | 1 | Fetch data returned |
| rsp_data | input | 16 | Returned bus data |
| pop_req | input | 1 | Execution side takes one byte |
| pop_valid | output | 1 | Queue holds at least one byte |
| pop_byte | output | 8 | Oldest queued byte |

## Verification
Two events can fall in the same cycle: a flush and the completion of the fetch issued before it. Either order of the two must leave only new-location bytes in the queue. The stimulus keeps the response delay random between zero and three cycles and often flushes while a fetch is outstanding. This makes the flush land before the response, in the same cycle as the response, and after it. A bench model tracks the expected pop location from the flush target. It judges every popped byte against a fixed address-derived byte pattern, so one stale byte that reaches the queue shows up as a data mismatch.

// File: rtl/pf_pkg.sv
`timescale 1ns/1ps
package pf_pkg;
   localparam int SEG_W     = 16;
   localparam int OFF_W     = 16;
   localparam int SEG_SHIFT = 4;
   localparam int PA_W      = 20;
   localparam int BYTE_W    = 8;

   typedef logic [BYTE_W-1:0] byte_t;

   // segment moved up by SEG_SHIFT plus zero-extended offset, truncated to PA_W
   function automatic logic [PA_W-1:0] phys_addr(input logic [SEG_W-1:0] seg,
                                                  input logic [OFF_W-1:0] off);
      logic [PA_W-1:0] base;
      logic [PA_W-1:0] ofs;
      base = PA_W'({seg, {SEG_SHIFT{1'b0}}});
      ofs  = PA_W'(off);
      return base + ofs;
   endfunction
endpackage

// File: rtl/pf_addr_gen.sv
`timescale 1ns/1ps
module pf_addr_gen #(
   parameter int BUS_W = 16,
   parameter int CNT_W = 3
) (
   input  logic [pf_pkg::SEG_W-1:0] seg,
   input  logic [pf_pkg::OFF_W-1:0] off,
   input  logic [CNT_W-1:0]         free_slots,
   output logic [pf_pkg::PA_W-1:0]  phys,
   output logic [1:0]               need,
   output logic                     room,
   output logic                     bhe_n_act
);
   assign phys = pf_pkg::phys_addr(seg, off);

   generate
      if (BUS_W == 16) begin : g_wide
         // odd address: high lane only; even address: whole word
         assign need      = off[0] ? 2'd1 : 2'd2;
         assign bhe_n_act = 1'b0;
      end else begin : g_narrow
         assign need      = 2'd1;
         assign bhe_n_act = 1'b1;
      end
   endgenerate

   assign room = (free_slots >= CNT_W'(need));
endmodule

// File: rtl/pf_byte_fifo.sv
`timescale 1ns/1ps
module pf_byte_fifo #(
   parameter int DEPTH = 6,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clear,
   input  logic [1:0]         wr_cnt,
   input  pf_pkg::byte_t      wr_first,
   input  pf_pkg::byte_t      wr_second,
   input  logic               rd_en,
   output pf_pkg::byte_t      rd_data,
   output logic [CNT_W-1:0]   count
);
   pf_pkg::byte_t    mem [DEPTH];
   logic [PTR_W-1:0] wptr, rptr;

   function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      if (!clear) begin
         if (wr_cnt != 2'd0) mem[wptr]       <= wr_first;
         if (wr_cnt == 2'd2) mem[step(wptr)] <= wr_second;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (wr_cnt == 2'd2)      wptr <= step(step(wptr));
         else if (wr_cnt == 2'd1) wptr <= step(wptr);
         if (rd_en) rptr <= step(rptr);
         count <= count + CNT_W'(wr_cnt) - CNT_W'(rd_en);
      end
   end

   assign rd_data = mem[rptr];

   a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));
   a_r10_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> (count != '0));
endmodule

// File: rtl/pf_prefetch_unit.sv
`timescale 1ns/1ps
module pf_prefetch_unit #(
   parameter int                       BUS_W   = 16,
   parameter int                       Q_DEPTH = 6,
   parameter logic [pf_pkg::SEG_W-1:0] RST_SEG = 16'hF000,
   parameter logic [pf_pkg::OFF_W-1:0] RST_OFF = 16'hFFF0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     flush,
   input  logic [pf_pkg::SEG_W-1:0] flush_seg,
   input  logic [pf_pkg::OFF_W-1:0] flush_off,
   input  logic                     op_claim,
   output logic                     req_valid,
   input  logic                     req_ready,
   output logic [pf_pkg::PA_W-1:0]  req_addr,
   output logic                     req_bhe_n,
   input  logic                     rsp_valid,
   input  logic [BUS_W-1:0]         rsp_data,
   input  logic                     pop_req,
   output logic                     pop_valid,
   output logic [pf_pkg::BYTE_W-1:0] pop_byte
);
   localparam int CNT_W = $clog2(Q_DEPTH + 1);

   generate
      if (!(BUS_W == 8 || BUS_W == 16)) begin : g_bad_bus
         $error("pf_prefetch_unit: BUS_W must be 8 or 16");
      end
      if (Q_DEPTH < 4) begin : g_bad_depth
         $error("pf_prefetch_unit: Q_DEPTH must be at least 4");
      end
   endgenerate

   logic [pf_pkg::SEG_W-1:0] seg_q;
   logic [pf_pkg::OFF_W-1:0] off_q;
   logic                     busy_q;
   logic                     drop_q;
   logic [1:0]               need_q;

   logic [CNT_W-1:0]         q_count;
   logic [CNT_W-1:0]         q_free;
   logic [1:0]               need;
   logic                     room;
   logic                     bhe_n_act;
   logic                     accept;
   logic                     land;
   pf_pkg::byte_t            lane_first, lane_second;

   assign q_free = CNT_W'(Q_DEPTH) - q_count;

   pf_addr_gen #(.BUS_W(BUS_W), .CNT_W(CNT_W)) addr_i (
      .seg        (seg_q),
      .off        (off_q),
      .free_slots (q_free),
      .phys       (req_addr),
      .need       (need),
      .room       (room),
      .bhe_n_act  (bhe_n_act)
   );

   assign req_valid = !busy_q && !op_claim && !flush && room;
   assign req_bhe_n = req_valid ? bhe_n_act : 1'b1;
   assign accept    = req_valid && req_ready;
   assign land      = busy_q && rsp_valid && !drop_q && !flush;

   generate
      if (BUS_W == 16) begin : g_wide_lanes
         assign lane_first  = (need_q == 2'd1) ? rsp_data[15:8] : rsp_data[7:0];
         assign lane_second = rsp_data[15:8];

         a_r4_word_room: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && !req_addr[0]) |-> (q_count <= CNT_W'(Q_DEPTH - 2)));
      end else begin : g_narrow_lanes
         assign lane_first  = rsp_data[7:0];
         assign lane_second = rsp_data[7:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seg_q  <= RST_SEG;
         off_q  <= RST_OFF;
         busy_q <= 1'b0;
         drop_q <= 1'b0;
         need_q <= 2'd0;
      end else begin
         if (accept) begin
            busy_q <= 1'b1;
            need_q <= need;
            drop_q <= 1'b0;
         end else if (busy_q && rsp_valid) begin
            busy_q <= 1'b0;
            drop_q <= 1'b0;
         end
         if (land) off_q <= off_q + pf_pkg::OFF_W'(need_q);
         if (flush) begin
            seg_q  <= flush_seg;
            off_q  <= flush_off;
            drop_q <= busy_q && !rsp_valid;
         end
      end
   end

   pf_byte_fifo #(.DEPTH(Q_DEPTH)) fifo_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (flush),
      .wr_cnt    (land ? need_q : 2'd0),
      .wr_first  (lane_first),
      .wr_second (lane_second),
      .rd_en     (pop_req && pop_valid),
      .rd_data   (pop_byte),
      .count     (q_count)
   );

   assign pop_valid = (q_count != '0);

   a_r7_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> !req_valid);
   a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !pop_valid);
   a_r8_flush_restart: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (req_addr == (({4'b0, $past(flush_seg)} << 4) + {4'b0, $past(flush_off)})));
   a_r3_idle_lanes: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_valid) |-> req_bhe_n);
endmodule

// File: tb/pf_prefetch_unit_tb_top.sv
`timescale 1ns/1ps
module pf_prefetch_unit_tb_top;
   localparam int QD = 6;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        flush;
   logic [15:0] flush_seg, flush_off;
   logic        op_claim;
   logic        req_valid, req_ready;
   logic [19:0] req_addr;
   logic        req_bhe_n;
   logic        rsp_valid;
   logic [15:0] rsp_data;
   logic        pop_req, pop_valid;
   logic [7:0]  pop_byte;

   always #10 clk = ~clk;

   pf_prefetch_unit #(.BUS_W(16), .Q_DEPTH(QD)) dut_i (
      .clk(clk), .rst_n(rst_n), .flush(flush), .flush_seg(flush_seg),
      .flush_off(flush_off), .op_claim(op_claim), .req_valid(req_valid),
      .req_ready(req_ready), .req_addr(req_addr), .req_bhe_n(req_bhe_n),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .pop_req(pop_req),
      .pop_valid(pop_valid), .pop_byte(pop_byte)
   );

   int n_checks = 0;
   int n_errors = 0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   function automatic logic [19:0] pa(input logic [15:0] s, input logic [15:0] o);
      logic [19:0] b;
      b = {s, 4'h0};
      return b + {4'h0, o};
   endfunction

   function automatic logic [7:0] mb(input logic [19:0] p);
      return p[7:0] ^ {p[19:16], p[11:8]} ^ (p[15:8] + 8'h5a);
   endfunction

   // bench model
   int          mcount;
   logic [15:0] fseg, fo, pseg, poff;
   bit          outst, disc;
   logic [19:0] oaddr;
   int          lat;
   int          r_pop, r_claim, r_ready, r_flush;
   bit          force_fl;
   logic [15:0] ff_seg, ff_off;

   task automatic cycle();
      bit          fl, pop_now, rsp_now, acc;
      int          nb, need;
      logic        exp_rv;
      logic [15:0] s, o;
      @(negedge clk);
      if (force_fl) begin
         fl = 1'b1; s = ff_seg; o = ff_off; force_fl = 1'b0;
      end else begin
         fl = (($urandom % 100) < r_flush);
         if (r_flush > 3 && outst && lat > 0 && ($urandom % 100) < 30) fl = 1'b1;
         s = 16'($urandom);
         o = (($urandom % 4) == 0) ? 16'hFFF8 + 16'($urandom % 8) : 16'($urandom);
      end
      flush     = fl;
      flush_seg = s;
      flush_off = o;
      op_claim  = (($urandom % 100) < r_claim);
      req_ready = (($urandom % 100) < r_ready);
      pop_req   = (($urandom % 100) < r_pop);
      rsp_now   = outst && (lat == 0);
      rsp_valid = rsp_now;
      if (rsp_now)
         rsp_data = oaddr[0] ? {mb(oaddr), 8'($urandom)} : {mb(oaddr + 20'd1), mb(oaddr)};
      else
         rsp_data = 16'($urandom);
      #1;
      // R5 R10: pop side
      chk(pop_valid == (mcount != 0), "R10", "pop_valid", 32'(pop_valid), 32'(mcount != 0));
      pop_now = pop_req && (mcount != 0);
      if (pop_now) begin
         chk(pop_byte == mb(pa(pseg, poff)), "R5 R9", "pop_byte", 32'(pop_byte),
             32'(mb(pa(pseg, poff))));
         poff = poff + 16'd1;
      end
      // R4 R6 R7: request offer
      need   = fo[0] ? 1 : 2;
      exp_rv = !outst && !op_claim && !fl && ((QD - mcount) >= need);
      chk(req_valid == exp_rv, "R4 R6 R7", "req_valid", 32'(req_valid), 32'(exp_rv));
      if (req_valid) begin
         chk(req_addr == pa(fseg, fo), "R1", "req_addr", 32'(req_addr), 32'(pa(fseg, fo)));
         chk(req_bhe_n == 1'b0, "R3", "bhe_n on request", 32'(req_bhe_n), 32'd0);
      end else begin
         chk(req_bhe_n == 1'b1, "R3", "bhe_n idle", 32'(req_bhe_n), 32'd1);
      end
      // model update
      if (rsp_now) begin
         nb = oaddr[0] ? 1 : 2;
         if (!disc && !fl) begin
            mcount += nb;
            fo = fo + 16'(nb);
         end
         outst = 1'b0;
         disc  = 1'b0;
      end
      acc = req_valid && req_ready;
      if (pop_now) mcount--;
      if (outst && lat > 0) lat--;
      if (acc) begin
         outst = 1'b1;
         disc  = 1'b0;
         oaddr = req_addr;
         lat   = int'($urandom % 4);
      end
      chk(mcount <= QD, "R5", "queue bound", 32'(mcount), 32'(QD));
      if (fl) begin
         mcount = 0;
         fseg = s; pseg = s; fo = o; poff = o;
         if (outst) disc = 1'b1;
      end
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) cycle();
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      rst_n = 1'b0; flush = 1'b0; flush_seg = '0; flush_off = '0;
      op_claim = 1'b0; req_ready = 1'b0; rsp_valid = 1'b0; rsp_data = '0;
      pop_req = 1'b0;
      mcount = 0; outst = 1'b0; disc = 1'b0; lat = 0; oaddr = '0;
      fseg = 16'hF000; fo = 16'hFFF0; pseg = 16'hF000; poff = 16'hFFF0;
      force_fl = 1'b0; ff_seg = '0; ff_off = '0;
      repeat (3) @(negedge clk);
      #1;
      chk(pop_valid == 1'b0, "R2", "pop_valid in reset", 32'(pop_valid), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R2: first fetch location after reset
      chk(pop_valid == 1'b0, "R2", "queue empty after reset", 32'(pop_valid), 32'd0);
      chk(req_valid == 1'b1, "R2", "first request offered", 32'(req_valid), 32'd1);
      chk(req_addr == 20'hFFFF0, "R2", "first address", 32'(req_addr), 32'hFFFF0);

      // reset location, even word fetches, moderate traffic
      r_pop = 70; r_claim = 20; r_ready = 70; r_flush = 0;
      run(200);

      // R1 wrap of the physical address
      force_fl = 1'b1; ff_seg = 16'hFFFF; ff_off = 16'h0010;
      run(300);

      // R9 offset wrap inside the segment, odd start
      force_fl = 1'b1; ff_seg = 16'h1234; ff_off = 16'hFFFD;
      run(300);

      // R4 R5 queue filling with rare pops
      r_pop = 8; r_claim = 10; r_ready = 90;
      force_fl = 1'b1; ff_seg = 16'h0400; ff_off = 16'h0001;
      run(800);

      // mixed random traffic with flushes
      r_pop = 70; r_claim = 20; r_ready = 70; r_flush = 2;
      run(1500);

      // R8 flush against outstanding fetches, heavy claim
      r_pop = 95; r_claim = 40; r_ready = 50; r_flush = 5;
      run(1500);

      // R6 bus mostly claimed
      r_pop = 50; r_claim = 85; r_ready = 80; r_flush = 1;
      run(600);

      summary();
      $finish;
   end
endmodule